// File: doc/BRIEF.md
# DRAM Refresh Timer and Sequencer

This block keeps a DRAM array of up to four banks alive by running periodic RAS-only refresh cycles. A free-running divide-by-16 prescaler clocks an interval down-counter. The counter reloads from a programmable scalar each time it expires, and each expiry raises one refresh request. Requests that cannot be served at once wait in a small queue of up to three entries. While any request waits, the block asks the memory arbiter for the bus. A cycle starts on the clock after the arbiter grants it. Each cycle strobes the RAS line of every populated bank together for three clocks and presents a 10-bit refresh row address. The address steps by one after every cycle.

A request that has waited a whole interval raises a high-priority flag, which tells the arbiter to serve the queue back to back ahead of other requestors. Leaving reset, the queue holds three requests and the flag is high, so the array gets a burst of three refreshes before any other memory cycle. Normal reset leaves the row address alone, so a warm reset continues at the correct row. With the test-mode input high during reset, the address loads a known value instead.

Top module: `dram_refresh_seq`

## Requirements
- R1: With scalar S sampled while reset is low, refresh requests enter the queue at clock edges 16·(S+1)·k after reset release (edge 1 is the first edge with reset high), for k = 1, 2, …; S is re-sampled at every reload. The default scalar value is 18, a period of 304 clocks.
- R2: At most three requests are pending. A request that arrives while three are pending, and no cycle starts on that edge, is dropped. Exactly three cycles are served once the queue is drained.
- R3: `req_o` is high exactly when at least one request is pending and no cycle is running. A cycle begins on the edge where `req_o` and `grant_i` are both high. RAS stays asserted for exactly 3 clocks, and `req_o` is low throughout.
- R4: During a cycle, `ras_n_o[i]` is low exactly for i ≤ `bank_cnt_i` (0 means one bank, 3 means four banks). The other lines stay high. Outside a cycle all four lines are high.
- R5: Leaving reset, three requests are pending and `hipri_o` is high.
- R6: `hipri_o` rises when a request is accepted while another is already pending. It falls on the edge where the queue empties, and it is never high with an empty queue.
- R7: `row_o` shows the row of the cycle in progress. It increments by one, modulo 1024, on the edge that ends each cycle.
- R8: A reset with `test_mode_i` low leaves `row_o` unchanged.
- R9: A reset with `test_mode_i` high loads `row_o` with 10'h3FE.
- R10: While reset is low, no cycle runs and all RAS lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scalar_i | input | 8 | Refresh interval scalar (interval = scalar+1 prescaler ticks) |
| bank_cnt_i | input | 2 | Populated banks minus one |
| test_mode_i | input | 1 | Load the known row address during reset |
| grant_i | input | 1 | Bus grant from the arbiter |
| req_o | output | 1 | Refresh bus request |
| hipri_o | output | 1 | Escalated refresh priority |
| ras_n_o | output | 4 | Active-low row strobes, one per bank |
| row_o | output | 10 | Refresh row address |

## Verification
Every output comes from registers that change on the edge that samples the stimulus, so the result is due one edge later. A grant seen on edge n drops RAS after edge n and releases it after edge n+3. The row moves on that same release edge. A request due at edge 16·(S+1)·k raises `req_o` right after that edge. The bench numbers the edges from reset release, drives and samples one nanosecond after each edge, and compares each result at the edge where the requirement places it. In the randomized part, the bench counts cycles over the whole run and checks each one at its first clock.

// File: rtl/refresh_pkg.sv
// Package: shared constants and types for the refresh sequencer.
// Assumes a queue depth of three and a fixed three-clock refresh cycle.
package refresh_pkg;
    localparam int unsigned CYC_CLKS = 3;
    localparam int unsigned PH_W     = $clog2(CYC_CLKS);
    typedef logic [1:0] pend_t;
    localparam pend_t MAX_PEND = 2'd3;
endpackage

// File: rtl/refresh_prescale.sv
// Module: free-running clock divider; pulses tick_o once every 2**DIV_W clocks.
// Assumes the divider restarts at zero while reset is low.
module refresh_prescale #(
    parameter int unsigned DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [DIV_W-1:0] div_q;

    // Count clocks; wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + DIV_W'(1);
    end

    assign tick_o = &div_q;
endmodule

// File: rtl/refresh_interval.sv
// Module: interval down-counter; reloads from the scalar and flags fire_o on expiry.
// Assumes the scalar is sampled during reset and at each reload.
module refresh_interval #(
    parameter int unsigned SCALAR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [SCALAR_W-1:0] scalar_i,
    output logic                fire_o
);
    logic [SCALAR_W-1:0] cnt_q;

    // Load on reset, reload on expiry, else step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= scalar_i;
        else if (tick_i) begin
            if (cnt_q == '0)     cnt_q <= scalar_i;
            else                 cnt_q <= cnt_q - SCALAR_W'(1);
        end
    end

    assign fire_o = tick_i && (cnt_q == '0);
endmodule

// File: rtl/refresh_queue.sv
// Module: pending-request counter (depth 3) with priority escalation.
// Assumes start_i only occurs while the count is nonzero.
module refresh_queue
    import refresh_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fire_i,
    input  logic  start_i,
    output pend_t pend_o,
    output logic  hipri_o
);
    pend_t pend_q, pend_n;
    logic  hipri_q;
    logic  accept;

    // A new request is kept unless the queue is full and nothing leaves it.
    always_comb begin
        accept = fire_i && ((pend_q != MAX_PEND) || start_i);
        pend_n = pend_q;
        if (accept && !start_i)      pend_n = pend_q + 2'd1;
        else if (!accept && start_i) pend_n = pend_q - 2'd1;
    end

    // Reset preloads the startup burst; escalate on a second waiter, clear on empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= MAX_PEND;
            hipri_q <= 1'b1;
        end else begin
            pend_q <= pend_n;
            if (pend_n == 2'd0)                hipri_q <= 1'b0;
            else if (accept && pend_q != 2'd0) hipri_q <= 1'b1;
        end
    end

    assign pend_o  = pend_q;
    assign hipri_o = hipri_q;
endmodule

// File: rtl/refresh_cycle.sv
// Module: runs one RAS-only refresh cycle per start and owns the row address.
// Assumes start_i never arrives while a cycle is running. The row is kept
// through reset unless test_mode_i is high.
module refresh_cycle
    import refresh_pkg::*;
#(
    parameter int unsigned BANKS    = 4,
    parameter int unsigned ROW_W    = 10,
    parameter logic [ROW_W-1:0] TEST_ROW = 10'h3FE,
    localparam int unsigned BANK_W  = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode_i,
    input  logic [BANK_W-1:0] bank_cnt_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic [BANKS-1:0]  ras_n_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_CLKS - 1);

    logic             busy_q;
    logic [PH_W-1:0]  ph_q;
    logic [ROW_W-1:0] row_q;
    logic [BANKS-1:0] populated;

    // One enable per bank: banks up to the configured count are populated.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign populated[b] = (BANK_W'(b) <= bank_cnt_i);
    end

    // Cycle phase, busy flag and row stepping at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            if (test_mode_i) row_q <= TEST_ROW;
        end else if (start_i) begin
            busy_q <= 1'b1;
            ph_q   <= '0;
        end else if (busy_q) begin
            if (ph_q == LAST_PH) begin
                busy_q <= 1'b0;
                row_q  <= row_q + ROW_W'(1);
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end
    end

    assign busy_o  = busy_q;
    assign ras_n_o = busy_q ? ~populated : '1;
    assign row_o   = row_q;
endmodule

// File: rtl/dram_refresh_seq.sv
// Module: top of the refresh timer and sequencer. Joins prescaler, interval
// counter, request queue and cycle generator; handshakes with the arbiter.
// Assumes grant_i is only meaningful while req_o is high.
module dram_refresh_seq
    import refresh_pkg::*;
#(
    parameter int unsigned DIV_W    = 4,
    parameter int unsigned SCALAR_W = 8,
    parameter int unsigned BANKS    = 4,
    parameter int unsigned ROW_W    = 10,
    parameter logic [ROW_W-1:0] TEST_ROW = 10'h3FE,
    localparam int unsigned BANK_W  = $clog2(BANKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SCALAR_W-1:0] scalar_i,
    input  logic [BANK_W-1:0]   bank_cnt_i,
    input  logic                test_mode_i,
    input  logic                grant_i,
    output logic                req_o,
    output logic                hipri_o,
    output logic [BANKS-1:0]    ras_n_o,
    output logic [ROW_W-1:0]    row_o
);
    logic  tick, fire, start, busy;
    pend_t pend;

    refresh_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    refresh_interval #(.SCALAR_W(SCALAR_W)) u_ivl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .scalar_i(scalar_i), .fire_o(fire)
    );

    refresh_queue u_queue (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .start_i(start),
        .pend_o(pend), .hipri_o(hipri_o)
    );

    refresh_cycle #(.BANKS(BANKS), .ROW_W(ROW_W), .TEST_ROW(TEST_ROW)) u_cyc (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i), .bank_cnt_i(bank_cnt_i),
        .start_i(start), .busy_o(busy), .ras_n_o(ras_n_o), .row_o(row_o)
    );

    // Request while work waits and the strobes are idle; start on grant.
    assign req_o = (pend != 2'd0) && !busy;
    assign start = req_o && grant_i;
endmodule

// File: rtl/refresh_seq_checker.sv
// Module: protocol checker for dram_refresh_seq, attached by bind below.
module refresh_seq_checker #(
    parameter int unsigned BANKS = 4,
    parameter int unsigned ROW_W = 10,
    localparam int unsigned BANK_W = $clog2(BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant_i,
    input logic [BANK_W-1:0] bank_cnt_i,
    input logic              req_o,
    input logic              hipri_o,
    input logic [BANKS-1:0]  ras_n_o,
    input logic [ROW_W-1:0]  row_o,
    input logic [1:0]        pend
);
    logic [BANKS-1:0] exp_low;
    for (genvar b = 0; b < BANKS; b++) begin : g_exp
        assign exp_low[b] = (b <= int'(bank_cnt_i));
    end

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && grant_i) |=> (ras_n_o != '1));

    p_no_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n_o != '1) |-> !req_o);

    p_ras_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ras_n_o != '1) && ($past(ras_n_o) == '1))
        |=> (ras_n_o != '1) ##1 (ras_n_o != '1) ##1 (ras_n_o == '1));

    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n_o != '1) |-> (~ras_n_o == exp_low));

    p_hipri_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hipri_o |-> (pend != 2'd0));

    p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ras_n_o) != '1) && (ras_n_o == '1)) |-> (row_o == $past(row_o) + ROW_W'(1)));
endmodule

bind dram_refresh_seq refresh_seq_checker #(.BANKS(BANKS), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .bank_cnt_i(bank_cnt_i),
    .req_o(req_o), .hipri_o(hipri_o), .ras_n_o(ras_n_o), .row_o(row_o), .pend(pend)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] scalar;
    logic [1:0] bank_cnt;
    logic       test_mode;
    logic       grant;
    logic       req, hipri;
    logic [3:0] ras_n;
    logic [9:0] row;

    int n_chk  = 0;
    int n_fail = 0;
    int edges  = 0;

    always #4 clk = ~clk;

    dram_refresh_seq u_dut (
        .clk(clk), .rst_n(rst_n), .scalar_i(scalar), .bank_cnt_i(bank_cnt),
        .test_mode_i(test_mode), .grant_i(grant), .req_o(req), .hipri_o(hipri),
        .ras_n_o(ras_n), .row_o(row)
    );

    function automatic int exp_mask(int n);
        return (~((1 << (n + 1)) - 1)) & 4'hF;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance to edge number e (counted from reset release), then settle 1 ns.
    task automatic go_to(int e);
        while (edges < e) begin
            @(posedge clk);
            edges++;
        end
        #1;
    endtask

    task automatic do_reset(int s, int b, bit tm, bit g);
        @(posedge clk); #1;
        rst_n = 1'b0; scalar = 8'(s); bank_cnt = 2'(b); test_mode = tm; grant = g;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 ras idle in reset", ras_n, 4'hF);
        rst_n = 1'b1;
        edges = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [9:0] row0, last_row, nxt;
        int runlen, cycles;
        bit have_row;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; scalar = 8'd18; bank_cnt = 2'd3; test_mode = 1'b1; grant = 1'b1;

        // Session 1: test-mode reset, default scalar, four banks.
        do_reset(18, 3, 1'b1, 1'b1);
        go_to(1);
        chk("R9 test row", row, 10'h3FE);
        chk("R4 four-bank mask", ras_n, 4'h0);
        chk("R5 hipri after reset", hipri, 1);
        chk("R3 req low in cycle", req, 0);
        go_to(4);
        chk("R3 ras released after 3 clocks", ras_n, 4'hF);
        go_to(5);
        chk("R7 row step", row, 10'h3FF);
        go_to(9);
        chk("R7 row wrap", row, 10'h000);
        chk("R6 hipri clears on empty", hipri, 0);
        go_to(12);
        chk("R5 burst done, no req", req, 0);
        grant = 1'b0;
        go_to(303);
        chk("R1 no request before period", req, 0);
        go_to(304);
        chk("R1 request at 304 clocks", req, 1);
        chk("R6 single waiter not escalated", hipri, 0);
        grant = 1'b1;
        go_to(305);
        chk("R7 row after burst", row, 10'h001);
        go_to(308);
        chk("R3 cycle end", ras_n, 4'hF);
        row0 = row;

        // Session 2: warm reset, scalar 1 (32 clocks), two banks.
        do_reset(1, 1, 1'b0, 1'b1);
        go_to(1);
        chk("R8 row kept over warm reset", row, row0);
        chk("R4 two-bank mask", ras_n, 4'hC);
        go_to(12);
        grant = 1'b0;
        go_to(32);
        chk("R1 request at 32", req, 1);
        chk("R6 no escalation with one", hipri, 0);
        go_to(64);
        chk("R6 escalation on second", hipri, 1);
        go_to(130);
        grant = 1'b1;
        cycles = 0;
        for (int i = 131; i <= 155; i++) begin
            go_to(i);
            if (ras_n != 4'hF && i == 131) cycles++;
            else if (ras_n != 4'hF && i > 131) begin
                // counted on entry: check the previous edge via runlen below
            end
        end
        chk("R6 hipri cleared after drain", hipri, 0);
        chk("R2 queue still empty before next", req, 0);

        // Session 2b: count served cycles after overflow using a fresh window.
        grant = 1'b0;
        go_to(160);
        go_to(192);
        go_to(224);
        go_to(256);
        go_to(258);
        grant = 1'b1;
        cycles = 0; runlen = 0;
        for (int i = 259; i <= 285; i++) begin
            go_to(i);
            if (ras_n != 4'hF) begin
                if (runlen == 0) cycles++;
                runlen++;
            end else runlen = 0;
        end
        chk("R2 capped at three cycles", cycles, 3);

        // Session 3: random grants, scalar 2 (48 clocks), random bank count.
        begin
            int bk;
            bk = int'($urandom % 4);
            do_reset(2, bk, 1'b0, 1'b1);
            cycles = 0; runlen = 0; have_row = 0; last_row = '0;
            for (int i = 1; i <= 2040; i++) begin
                go_to(i);
                if (ras_n != 4'hF) begin
                    if (runlen == 0) begin
                        cycles++;
                        chk("R4 mask in random run", ras_n, exp_mask(bk));
                        if (have_row) begin
                            nxt = last_row + 10'd1;
                            chk("R7 consecutive rows", row, nxt);
                        end
                        last_row = row;
                        have_row = 1;
                    end
                    runlen++;
                end else begin
                    if (runlen != 0) chk("R3 cycle length", runlen, 3);
                    runlen = 0;
                end
                grant = (i < 2000) ? 1'($urandom % 2) : 1'b1;
            end
            chk("R1 total cycles over run", cycles, 3 + 2040 / 48);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule